// File: doc/BRIEF.md
# Packed Signed Saturating Adder

This block adds two packed operands lane by lane, and each lane clamps to its signed limits when the sum does not fit, so it never wraps. An opcode byte picks the lane size. The byte that follows the escape code selects 8-bit lanes when it is 0xEC and 16-bit lanes when it is 0xED. A separate flag tells the block whether the operand-size prefix 0x66 was present. With the prefix, the full 128 bits are processed. Without it, only the low 64 bits are processed, and the upper half of the result keeps the upper half of the destination operand `a_i`.

The result is registered, and the output strobe arrives one clock after an accepted input. Every active lane has its own saturation bit, so the caller can see which lanes were clamped. An opcode byte other than the two legal values raises an illegal indication for one cycle and produces no result. The block reads and writes no status flags.

Top module: `pk_sat_add`

## Requirements
- R1: In byte mode, each 8-bit lane whose signed sum lies within -128..127 returns the plain two's-complement sum.
- R2: In byte mode, a lane sum above 127 returns 0x7F, and a lane sum below -128 returns 0x80.
- R3: In word mode, each 16-bit lane returns the signed sum, or 0x7FFF when the sum is above 32767, or 0x8000 when it is below -32768.
- R4: Opcode byte 0xEC selects 8-bit lanes and 0xED selects 16-bit lanes.
- R5: When `wide` is 1, all 128 bits are processed. When it is 0, only bits 63:0 are processed, and result bits 127:64 equal `a_i[127:64]`.
- R6: Lane 0 sits at the least significant bits, and each lane result depends only on the same-numbered lanes of the two inputs.
- R7: `sat_o[k]` is 1 exactly when lane k clamped. In word mode, bits 15:8 are 0. In 64-bit mode, the bits of the upper lanes are 0.
- R8: `out_valid` is 1 in the cycle after an accepted `in_valid`, and 0 otherwise. `res_o` and `sat_o` update only on accepted inputs.
- R9: An illegal opcode with `in_valid` set drives `out_illegal` high for one cycle, keeps `out_valid` low, and leaves `res_o` and `sat_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 8 | Opcode byte after the escape code |
| wide | input | 1 | Operand-size prefix present (128-bit operation) |
| a_i | input | 128 | Destination operand |
| b_i | input | 128 | Source operand |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal opcode indication |
| res_o | output | 128 | Packed result |
| sat_o | output | 16 | Per-lane saturation bits |

## Verification
Every output comes from a single register stage. The result, the saturation bits, the valid strobe and the illegal strobe are therefore all due exactly one clock after the input cycle that caused them, and idle cycles are due to show both strobes low one clock later. The driver stamps each expected item with the cycle in which it was driven. The monitor samples at the falling edge and pops only items whose stamp is older than the current cycle, so each comparison lands on the cycle its result is due.

// File: rtl/pk_sat_add.sv
module pk_sat_add #(
  parameter int W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       opcode,
  input  logic             wide,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [W-1:0]     res_o,
  output logic [W/8-1:0]   sat_o
);
  localparam int NB  = W / 8;
  localparam int NW  = W / 16;
  localparam int NBH = NB / 2;
  localparam int NWH = NW / 2;

  logic          is_byte, is_word, legal;
  logic [W-1:0]  byte_res, word_res, next_res;
  logic [NB-1:0] byte_sat, next_sat;
  logic [NW-1:0] word_sat;

  assign is_byte = (opcode == 8'hEC);
  assign is_word = (opcode == 8'hED);
  assign legal   = is_byte | is_word;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam bit LOW = (i < NBH);
    logic [7:0] x, y, s;
    logic       ovf, act;
    assign x   = a_i[8*i +: 8];
    assign y   = b_i[8*i +: 8];
    assign s   = x + y;
    assign ovf = (x[7] == y[7]) && (s[7] != x[7]);
    assign act = LOW | wide;
    assign byte_res[8*i +: 8] = !act ? x : ovf ? (x[7] ? 8'h80 : 8'h7F) : s;
    assign byte_sat[i] = act & ovf;
  end

  for (genvar j = 0; j < NW; j++) begin : g_word
    localparam bit LOW = (j < NWH);
    logic [15:0] x, y, s;
    logic        ovf, act;
    assign x   = a_i[16*j +: 16];
    assign y   = b_i[16*j +: 16];
    assign s   = x + y;
    assign ovf = (x[15] == y[15]) && (s[15] != x[15]);
    assign act = LOW | wide;
    assign word_res[16*j +: 16] = !act ? x : ovf ? (x[15] ? 16'h8000 : 16'h7FFF) : s;
    assign word_sat[j] = act & ovf;
  end

  assign next_res = is_word ? word_res : byte_res;
  assign next_sat = is_word ? {{(NB-NW){1'b0}}, word_sat} : byte_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      res_o       <= '0;
      sat_o       <= '0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      if (in_valid && legal) begin
        res_o <= next_res;
        sat_o <= next_sat;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode == 8'hEC || opcode == 8'hED) |=> out_valid);

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode != 8'hEC && opcode != 8'hED |=>
      out_illegal && !out_valid && $stable(res_o) && $stable(sat_o));

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(wide) |-> res_o[W-1:W/2] == $past(a_i[W-1:W/2]));

  a_r7_upper_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(wide) |-> sat_o[NB-1:NBH] == '0);

  a_r3_word_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(opcode) == 8'hED |-> sat_o[NB-1:NW] == '0);
endmodule

// File: tb/pk_sat_add_tb.sv
module pk_sat_add_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 128;
  localparam int NB = W / 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, wide = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic out_valid, out_illegal;
  logic [W-1:0] res_o;
  logic [NB-1:0] sat_o;

  pk_sat_add #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .wide(wide),
    .a_i(a_i), .b_i(b_i), .out_valid(out_valid), .out_illegal(out_illegal),
    .res_o(res_o), .sat_o(sat_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int            stamp;
    int            kind;
    logic [W-1:0]  res;
    logic [NB-1:0] sat;
    string         tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  logic [W-1:0] last_res = '0;
  logic [NB-1:0] last_sat = '0;
  bit started = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] op,
                       input bit wd, output logic [W-1:0] r, output logic [NB-1:0] s);
    int lw, n, lo, hi;
    r = '0; s = '0;
    lw = (op == 8'hEC) ? 8 : 16;
    n  = W / lw;
    lo = (lw == 8) ? -128 : -32768;
    hi = (lw == 8) ? 127 : 32767;
    for (int k = 0; k < n; k++) begin
      int av, bv, sum;
      if (lw == 8) begin
        av = int'($signed(a[8*k +: 8])); bv = int'($signed(b[8*k +: 8]));
      end else begin
        av = int'($signed(a[16*k +: 16])); bv = int'($signed(b[16*k +: 16]));
      end
      sum = av + bv;
      if (!wd && k >= n/2) begin
        sum = av;
      end else if (sum > hi) begin
        sum = hi; s[k] = 1'b1;
      end else if (sum < lo) begin
        sum = lo; s[k] = 1'b1;
      end
      if (lw == 8) r[8*k +: 8] = sum[7:0];
      else         r[16*k +: 16] = sum[15:0];
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] op,
                       input bit wd, input string tag);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; opcode = op; wide = wd; in_valid = 1'b1;
    it.stamp = cyc; it.tag = tag;
    if (op == 8'hEC || op == 8'hED) begin
      it.kind = 1;
      model(a, b, op, wd, it.res, it.sat);
      last_res = it.res; last_sat = it.sat;
    end else begin
      it.kind = 2; it.res = last_res; it.sat = last_sat;
    end
    q.push_back(it);
    started = 1;
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b0; opcode = 8'hEC;
    it.stamp = cyc; it.kind = 0; it.res = last_res; it.sat = last_sat; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (started && q.size() > 0 && q[0].stamp < cyc) begin
      item_t it;
      it = q.pop_front();
      chk(out_valid == (it.kind == 1), {it.tag, " valid"}, W'(out_valid), W'(it.kind == 1));
      chk(out_illegal == (it.kind == 2), {it.tag, " illegal"}, W'(out_illegal), W'(it.kind == 2));
      chk(res_o == it.res, {it.tag, " result"}, res_o, it.res);
      chk(sat_o == it.sat, {it.tag, " sat"}, W'(sat_o), W'(it.sat));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_illegal, "reset strobes", W'({out_valid, out_illegal}), '0);
    chk(res_o == '0 && sat_o == '0, "reset result", res_o, '0);

    drive({16{8'h11}}, {16{8'h22}}, 8'hEC, 1, "R1 byte in range");
    drive(128'h0102_0304_0506_0708_F0F1_F2F3_F4F5_F6F7, 128'h1010_2020_3030_4040_0505_0A0A_FEFE_8080, 8'hEC, 1, "R6 R1 mixed lanes");
    drive({16{8'h7F}}, {16{8'h01}}, 8'hEC, 1, "R2 byte clamp high");
    drive({16{8'h80}}, {16{8'hFF}}, 8'hEC, 1, "R2 byte clamp low");
    drive(128'h7F80_7F80_0000_0000_4040_C0C0_0102_0304, 128'h0101_FFFF_7F80_1111_4040_C0C0_0101_0101, 8'hEC, 1, "R6 R7 per-lane clamp");
    idle("R8 idle gap");
    drive({8{16'h7FFF}}, {8{16'h0001}}, 8'hED, 1, "R3 word clamp high");
    drive({8{16'h8000}}, {8{16'h8000}}, 8'hED, 1, "R3 word clamp low");
    drive(128'h1234_7000_9000_0001_FFFF_4000_C000_0000, 128'h1111_1000_F000_FFFF_0001_4000_C000_0000, 8'hED, 1, "R4 R3 word mixed");
    drive({16{8'h7F}}, {16{8'h7F}}, 8'hEC, 0, "R5 R7 narrow byte");
    drive(128'hDEAD_BEEF_CAFE_F00D_7FFF_8000_0100_FFFF, {8{16'h7FFF}}, 8'hED, 0, "R5 narrow word");
    drive({16{8'h55}}, {16{8'h55}}, 8'hEE, 1, "R9 illegal opcode");
    drive({16{8'h01}}, {16{8'h01}}, 8'h0F, 0, "R9 illegal escape");
    drive({16{8'h40}}, {16{8'h40}}, 8'hEC, 1, "R8 R2 after illegal");
    drive({8{16'h4000}}, {8{16'h4000}}, 8'hEC, 1, "R4 byte view of word data");
    idle("R8 trailing idle");
    idle("R8 trailing idle 2");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule